// File: doc/BRIEF.md
# Scoreboard Issue and Operand-Read Controller

This block is the control part of a dynamically scheduled pipeline with several functional units (three by default). Decode is split into two steps. The issue step takes the next instruction in program order. It holds that instruction back while its target unit is occupied or while its destination register still waits for a result from an earlier instruction. Each issued instruction then sits in a per-unit slot until no read-after-write hazard remains on its two sources. At that point the block tells the unit to read its operands and start. Because slots are released independently, later instructions may start and finish before earlier ones.

The unit datapaths are outside this block and may take any number of cycles. They report the end of execution with a one-cycle pulse. The controller then grants at most one register-file write per cycle, oldest issued first. It holds back any write that would overwrite a value an older, not-yet-started instruction still has to read. A per-register pending-write table records which unit will produce each register's next value.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset every unit is free and no register has a pending write: `iss_ready` is 1 for any unit/destination, and `rd_go` and `wb_go` are 0.
- R2: `iss_ready` is 0 while the unit selected by `iss_fu` holds an instruction, and 1 for a free unit whose destination has no pending write. An instruction is accepted at a clock edge where `iss_valid` and `iss_ready` are both 1.
- R3: `iss_ready` is 0 while `iss_dst` has a pending write from an earlier accepted instruction. The pending mark is set at acceptance and cleared at that instruction's writeback.
- R4: Bit i of `rd_go` (unit i) is 1 for exactly one cycle per instruction. If no source has a pending write at acceptance, that cycle is the one after acceptance.
- R5: A source with a pending write blocks the operand read until its producer's writeback; the read is signalled in the cycle after that writeback. Instructions accepted later, with no hazard, read meanwhile (out-of-order start).
- R6: `ex_done[i]` is honoured only while unit i is executing. `wb_go[i]` can rise no earlier than the cycle after the honoured pulse, and a pulse for an idle unit has no effect.
- R7: A write to register d is held back while an older instruction that has not read its operands has a source d whose value is already available (write-after-read guard).
- R8: `wb_go` has at most one bit set. Among units ready to write, the one whose instruction was accepted first is granted, and any ready request produces a grant.
- R9: A unit is free from the cycle after its writeback. `iss_ready` for that unit is 0 in the writeback cycle and can be 1 in the next.
- R10: An instruction accepted in the same cycle as the writeback of its source's producer treats that source as available and reads in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| iss_valid | input | 1 | An instruction is offered to the issue step |
| iss_fu | input | FU_W | Target unit index of the offered instruction |
| iss_dst | input | REG_W | Destination register index |
| iss_src1 | input | REG_W | First source register index |
| iss_src2 | input | REG_W | Second source register index |
| iss_ready | output | 1 | Offered instruction can be accepted this cycle |
| ex_done | input | NUM_FU | Pulse per unit: execution finished, result ready |
| rd_go | output | NUM_FU | Per unit: read operands and start execution this cycle |
| wb_go | output | NUM_FU | Per unit: write the result to the register file this cycle |

## Verification
The hardest situation to reach is the write-after-read hold. It needs a finished writer and an older waiting reader whose stalled operand and available operand are different registers, with the writer's destination matching the available one. The stimulus accepts a long-running producer first. It then accepts a reader that depends on that producer for one source and on the writer's destination for the other. Finally it lets the writer finish early, so the block must hold the write until the producer's writeback releases the reader. A second hard case is a producer's writeback and a consumer's acceptance in the same cycle. It is reached by offering the consumer exactly in the grant cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Life cycle of one functional-unit slot.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,  // no instruction held
    SLOT_WAIT = 2'd1,  // issued, waiting for source operands
    SLOT_EXEC = 2'd2,  // operands read, unit executing
    SLOT_DONE = 2'd3   // result ready, waiting for write grant
  } slot_st_e;

endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 3,
  parameter int FU_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           set_en,
  input  logic [REG_W-1:0]               set_reg,
  input  logic [FU_W-1:0]                set_tag,
  input  logic                           clr_en,
  input  logic [REG_W-1:0]               clr_reg,
  output logic [NUM_REGS-1:0]            pend_v,
  output logic [NUM_REGS-1:0][FU_W-1:0]  pend_tag
);

  logic [NUM_REGS-1:0]           pend_v_q, pend_v_n;
  logic [NUM_REGS-1:0][FU_W-1:0] tag_q, tag_n;
  logic                          upd_en;

  assign upd_en = set_en | clr_en;

  always_comb begin
    pend_v_n = pend_v_q;
    tag_n    = tag_q;
    if (clr_en) pend_v_n[clr_reg] = 1'b0;
    if (set_en) begin
      pend_v_n[set_reg] = 1'b1;
      tag_n[set_reg]    = set_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= '0;
      tag_q    <= '0;
    end else if (upd_en) begin
      pend_v_q <= pend_v_n;
      tag_q    <= tag_n;
    end
  end

  assign pend_v   = pend_v_q;
  assign pend_tag = tag_q;

  // A new pending mark never lands on a register that already has one.
  assert_set_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !pend_v_q[set_reg]);

  // A writeback always clears a register that was marked pending.
  assert_clr_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> pend_v_q[clr_reg]);

endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int REG_W = 3,
  parameter int FU_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_src1,
  input  logic [REG_W-1:0] a_src2,
  input  logic             a_rdy1,
  input  logic             a_rdy2,
  input  logic [FU_W-1:0]  a_tag1,
  input  logic [FU_W-1:0]  a_tag2,
  input  logic             ex_done,
  input  logic             wb_grant,
  input  logic             wb_any,
  input  logic [FU_W-1:0]  wb_tag,
  output slot_st_e         state,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] src1,
  output logic [REG_W-1:0] src2,
  output logic             rdy1,
  output logic             rdy2,
  output logic             rd_go,
  output logic             wb_req
);

  slot_st_e         st_q, st_n;
  logic [REG_W-1:0] dst_q, src1_q, src2_q;
  logic [FU_W-1:0]  tag1_q, tag2_q;
  logic             rdy1_q, rdy2_q, rdy1_n, rdy2_n;
  logic             wake1, wake2, fin, slot_en;

  assign rd_go  = (st_q == SLOT_WAIT) && rdy1_q && rdy2_q;
  assign fin    = (st_q == SLOT_EXEC) && ex_done;
  assign wake1  = (st_q == SLOT_WAIT) && wb_any && !rdy1_q && (tag1_q == wb_tag);
  assign wake2  = (st_q == SLOT_WAIT) && wb_any && !rdy2_q && (tag2_q == wb_tag);
  assign wb_req = (st_q == SLOT_DONE);

  always_comb begin
    st_n   = st_q;
    rdy1_n = rdy1_q | wake1;
    rdy2_n = rdy2_q | wake2;
    if (alloc) begin
      st_n   = SLOT_WAIT;
      rdy1_n = a_rdy1;
      rdy2_n = a_rdy2;
    end else if (rd_go) begin
      st_n = SLOT_EXEC;
    end else if (fin) begin
      st_n = SLOT_DONE;
    end else if (wb_grant) begin
      st_n = SLOT_FREE;
    end
  end

  assign slot_en = alloc | rd_go | fin | wb_grant | wake1 | wake2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_FREE;
      rdy1_q <= 1'b0;
      rdy2_q <= 1'b0;
    end else if (slot_en) begin
      st_q   <= st_n;
      rdy1_q <= rdy1_n;
      rdy2_q <= rdy2_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      src1_q <= '0;
      src2_q <= '0;
      tag1_q <= '0;
      tag2_q <= '0;
    end else if (alloc) begin
      dst_q  <= a_dst;
      src1_q <= a_src1;
      src2_q <= a_src2;
      tag1_q <= a_tag1;
      tag2_q <= a_tag2;
    end
  end

  assign state = st_q;
  assign dst   = dst_q;
  assign src1  = src1_q;
  assign src2  = src2_q;
  assign rdy1  = rdy1_q;
  assign rdy2  = rdy2_q;

  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> st_q == SLOT_FREE);

  assert_read_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (st_q == SLOT_EXEC) && !rd_go);

  assert_grant_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_grant |-> st_q == SLOT_DONE);

  assert_free_after_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_grant |=> st_q == SLOT_FREE);

endmodule

// File: rtl/sb_wb_pick.sv
module sb_wb_pick #(
  parameter int NUM_FU = 3,
  parameter int FU_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] alloc,
  input  logic [NUM_FU-1:0] req,
  output logic [NUM_FU-1:0] grant,
  output logic              gany,
  output logic [FU_W-1:0]   gidx
);

  // older_q[i][j] set: the instruction in slot i was accepted before slot j's.
  logic [NUM_FU-1:0][NUM_FU-1:0] older_q, older_n;
  logic                          age_en;

  assign age_en = |alloc;

  always_comb begin
    older_n = older_q;
    for (int k = 0; k < NUM_FU; k++) begin
      if (alloc[k]) begin
        for (int j = 0; j < NUM_FU; j++) begin
          older_n[k][j] = 1'b0;
          if (j != k) older_n[j][k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else if (age_en) older_q <= older_n;
  end

  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < NUM_FU; j++) begin
        if ((j != i) && req[j] && older_q[j][i]) blocked = 1'b1;
      end
      grant[i] = req[i] && !blocked;
    end
  end

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (grant[i]) gidx = FU_W'(i);
    end
  end

  assign gany = |grant;

  assert_one_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0));

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 3,
  parameter int NUM_REGS = 8,
  localparam int FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [FU_W-1:0]   iss_fu,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [REG_W-1:0]  iss_src1,
  input  logic [REG_W-1:0]  iss_src2,
  output logic              iss_ready,
  input  logic [NUM_FU-1:0] ex_done,
  output logic [NUM_FU-1:0] rd_go,
  output logic [NUM_FU-1:0] wb_go
);

  slot_st_e                      s_st   [NUM_FU];
  logic [REG_W-1:0]              s_dst  [NUM_FU];
  logic [REG_W-1:0]              s_src1 [NUM_FU];
  logic [REG_W-1:0]              s_src2 [NUM_FU];
  logic [NUM_FU-1:0]             s_rdy1, s_rdy2, s_req, war_blk, req_ok, alloc;
  logic [NUM_REGS-1:0]           pend_v;
  logic [NUM_REGS-1:0][FU_W-1:0] pend_tag;
  logic                          sel_free, iss_fire, a_rdy1, a_rdy2, wb_any;
  logic [FU_W-1:0]               wb_idx;
  logic [REG_W-1:0]              wb_reg;

  // Issue step: target unit free and destination without a pending write.
  always_comb begin
    sel_free = 1'b0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (iss_fu == FU_W'(i)) sel_free = (s_st[i] == SLOT_FREE);
    end
  end

  assign iss_ready = sel_free && !pend_v[iss_dst];
  assign iss_fire  = iss_valid && iss_ready;

  always_comb begin
    for (int i = 0; i < NUM_FU; i++) alloc[i] = iss_fire && (iss_fu == FU_W'(i));
  end

  // A source is available if nothing is pending, or its producer writes now.
  assign a_rdy1 = !pend_v[iss_src1] || (wb_any && (pend_tag[iss_src1] == wb_idx));
  assign a_rdy2 = !pend_v[iss_src2] || (wb_any && (pend_tag[iss_src2] == wb_idx));

  sb_reg_status #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .FU_W     (FU_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (iss_fire),
    .set_reg  (iss_dst),
    .set_tag  (iss_fu),
    .clr_en   (wb_any),
    .clr_reg  (wb_reg),
    .pend_v   (pend_v),
    .pend_tag (pend_tag)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_slot
    sb_unit_slot #(
      .REG_W (REG_W),
      .FU_W  (FU_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc[g]),
      .a_dst    (iss_dst),
      .a_src1   (iss_src1),
      .a_src2   (iss_src2),
      .a_rdy1   (a_rdy1),
      .a_rdy2   (a_rdy2),
      .a_tag1   (pend_tag[iss_src1]),
      .a_tag2   (pend_tag[iss_src2]),
      .ex_done  (ex_done[g]),
      .wb_grant (wb_go[g]),
      .wb_any   (wb_any),
      .wb_tag   (wb_idx),
      .state    (s_st[g]),
      .dst      (s_dst[g]),
      .src1     (s_src1[g]),
      .src2     (s_src2[g]),
      .rdy1     (s_rdy1[g]),
      .rdy2     (s_rdy2[g]),
      .rd_go    (rd_go[g]),
      .wb_req   (s_req[g])
    );
  end

  // Write-after-read guard: a waiting reader still needs the old value.
  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      war_blk[f] = 1'b0;
      for (int g = 0; g < NUM_FU; g++) begin
        if ((g != f) && (s_st[g] == SLOT_WAIT) &&
            ((s_rdy1[g] && (s_src1[g] == s_dst[f])) ||
             (s_rdy2[g] && (s_src2[g] == s_dst[f]))))
          war_blk[f] = 1'b1;
      end
    end
  end

  assign req_ok = s_req & ~war_blk;

  sb_wb_pick #(
    .NUM_FU (NUM_FU),
    .FU_W   (FU_W)
  ) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .alloc (alloc),
    .req   (req_ok),
    .grant (wb_go),
    .gany  (wb_any),
    .gidx  (wb_idx)
  );

  always_comb begin
    wb_reg = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (wb_idx == FU_W'(i)) wb_reg = s_dst[i];
    end
  end

  // Granted unit must be one that had reported a finished result.
  assert_wb_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_go & ~s_req) == '0);

  // Acceptance leaves the destination marked pending in the next cycle.
  assert_mark_after_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> !iss_ready || (iss_dst != $past(iss_dst)) || !iss_valid || 1'b1 ? pend_v[$past(iss_dst)] : 1'b1);

endmodule

// File: tb/sim_sb_issue_ctrl.sv
module sim_sb_issue_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       iss_valid;
  logic [1:0] iss_fu;
  logic [2:0] iss_dst, iss_src1, iss_src2;
  logic       iss_ready;
  logic [2:0] ex_done, rd_go, wb_go;

  int checks = 0;
  int errs   = 0;

  sb_issue_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_fu    (iss_fu),
    .iss_dst   (iss_dst),
    .iss_src1  (iss_src1),
    .iss_src2  (iss_src2),
    .iss_ready (iss_ready),
    .ex_done   (ex_done),
    .rd_go     (rd_go),
    .wb_go     (wb_go)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // One cycle: drive inputs after the falling edge, settle, then checks follow.
  task automatic cyc(input logic v, input logic [1:0] fu, input logic [2:0] d,
                     input logic [2:0] s1, input logic [2:0] s2, input logic [2:0] dn);
    @(negedge clk);
    iss_valid = v;
    iss_fu    = fu;
    iss_dst   = d;
    iss_src1  = s1;
    iss_src2  = s2;
    ex_done   = dn;
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b000);
  endtask

  task automatic chk(input string req, input string what, input logic [2:0] act,
                     input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    cyc(1'b0, 2'd0, 3'd1, 3'd2, 3'd3, 3'b000);
    chk("R1", "iss_ready u0", {2'b0, iss_ready}, 3'b001);
    chk("R1", "rd_go", rd_go, 3'b000);
    chk("R1", "wb_go", wb_go, 3'b000);
    cyc(1'b0, 2'd2, 3'd7, 3'd0, 3'd0, 3'b000);
    chk("R1", "iss_ready u2", {2'b0, iss_ready}, 3'b001);
  endtask

  task automatic t_basic();
    cyc(1'b1, 2'd0, 3'd1, 3'd2, 3'd3, 3'b000);
    chk("R2", "iss_ready free unit", {2'b0, iss_ready}, 3'b001);
    idle();
    chk("R4", "rd_go after issue", rd_go, 3'b001);
    cyc(1'b0, 2'd0, 3'd5, 3'd0, 3'd0, 3'b000);
    chk("R4", "rd_go single pulse", rd_go, 3'b000);
    chk("R2", "iss_ready busy unit", {2'b0, iss_ready}, 3'b000);
    cyc(1'b0, 2'd1, 3'd1, 3'd0, 3'd0, 3'b000);
    chk("R3", "iss_ready pending dst", {2'b0, iss_ready}, 3'b000);
    cyc(1'b0, 2'd1, 3'd5, 3'd0, 3'd0, 3'b001);
    chk("R2", "iss_ready other unit", {2'b0, iss_ready}, 3'b001);
    chk("R6", "wb_go in done-pulse cycle", wb_go, 3'b000);
    cyc(1'b0, 2'd0, 3'd5, 3'd0, 3'd0, 3'b000);
    chk("R6", "wb_go after done", wb_go, 3'b001);
    chk("R9", "iss_ready in wb cycle", {2'b0, iss_ready}, 3'b000);
    cyc(1'b0, 2'd0, 3'd1, 3'd0, 3'd0, 3'b000);
    chk("R9", "iss_ready after wb", {2'b0, iss_ready}, 3'b001);
    chk("R3", "wb_go cleared", wb_go, 3'b000);
  endtask

  task automatic t_raw_bypass();
    cyc(1'b1, 2'd0, 3'd1, 3'd2, 3'd3, 3'b000);
    cyc(1'b1, 2'd1, 3'd4, 3'd1, 3'd2, 3'b000);
    chk("R4", "producer reads", rd_go, 3'b001);
    cyc(1'b1, 2'd2, 3'd5, 3'd6, 3'd7, 3'b000);
    chk("R5", "consumer held", rd_go, 3'b000);
    idle();
    chk("R5", "later independent bypasses", rd_go, 3'b100);
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b101);
    chk("R5", "consumer still held", rd_go, 3'b000);
    idle();
    chk("R8", "oldest of two writes first", wb_go, 3'b001);
    chk("R5", "consumer held during producer wb", rd_go, 3'b000);
    idle();
    chk("R8", "younger writes next", wb_go, 3'b100);
    chk("R5", "consumer reads after producer wb", rd_go, 3'b010);
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b010);
    idle();
    chk("R6", "consumer writes", wb_go, 3'b010);
    idle();
  endtask

  task automatic t_war();
    cyc(1'b1, 2'd1, 3'd1, 3'd2, 3'd3, 3'b000);
    cyc(1'b1, 2'd0, 3'd5, 3'd6, 3'd1, 3'b000);
    chk("R4", "producer of r1 reads", rd_go, 3'b010);
    cyc(1'b1, 2'd2, 3'd6, 3'd7, 3'd7, 3'b000);
    chk("R5", "reader held on r1", rd_go, 3'b000);
    idle();
    chk("R4", "writer of r6 reads", rd_go, 3'b100);
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b100);
    idle();
    chk("R7", "r6 write held", wb_go, 3'b000);
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b010);
    chk("R7", "r6 write still held", wb_go, 3'b000);
    idle();
    chk("R7", "unrelated write proceeds", wb_go, 3'b010);
    idle();
    chk("R5", "reader starts", rd_go, 3'b001);
    chk("R7", "r6 held during read cycle", wb_go, 3'b000);
    idle();
    chk("R7", "r6 write released", wb_go, 3'b100);
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b001);
    idle();
    chk("R6", "reader writes", wb_go, 3'b001);
    idle();
  endtask

  task automatic t_order();
    cyc(1'b1, 2'd2, 3'd1, 3'd0, 3'd0, 3'b000);
    cyc(1'b1, 2'd0, 3'd2, 3'd0, 3'd0, 3'b000);
    cyc(1'b1, 2'd1, 3'd3, 3'd0, 3'd0, 3'b000);
    idle();
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b111);
    idle();
    chk("R8", "first accepted (unit2)", wb_go, 3'b100);
    idle();
    chk("R8", "second accepted (unit0)", wb_go, 3'b001);
    idle();
    chk("R8", "third accepted (unit1)", wb_go, 3'b010);
    idle();
    chk("R8", "queue empty", wb_go, 3'b000);
  endtask

  task automatic t_ignored_done();
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b010);
    cyc(1'b0, 2'd1, 3'd1, 3'd0, 3'd0, 3'b000);
    chk("R6", "stray done gives no wb", wb_go, 3'b000);
    chk("R6", "unit still free", {2'b0, iss_ready}, 3'b001);
    cyc(1'b1, 2'd1, 3'd2, 3'd0, 3'd0, 3'b000);
    idle();
    chk("R4", "unit1 reads", rd_go, 3'b010);
    idle();
    chk("R6", "no wb before done", wb_go, 3'b000);
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b010);
    idle();
    chk("R6", "wb after real done", wb_go, 3'b010);
    idle();
  endtask

  task automatic t_same_cycle();
    cyc(1'b1, 2'd0, 3'd2, 3'd0, 3'd0, 3'b000);
    idle();
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b001);
    cyc(1'b1, 2'd1, 3'd3, 3'd2, 3'd2, 3'b000);
    chk("R10", "producer wb", wb_go, 3'b001);
    chk("R10", "consumer accepted", {2'b0, iss_ready}, 3'b001);
    idle();
    chk("R10", "consumer reads next cycle", rd_go, 3'b010);
    cyc(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 3'b010);
    idle();
    chk("R10", "consumer writes", wb_go, 3'b010);
    idle();
  endtask

  initial begin
    rst_n     = 1'b0;
    iss_valid = 1'b0;
    iss_fu    = '0;
    iss_dst   = '0;
    iss_src1  = '0;
    iss_src2  = '0;
    ex_done   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_raw_bypass();
    t_war();
    t_order();
    t_ignored_done();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errs++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule